// File: doc/BRIEF.md
# Framebuffer VGA Scanout Engine

This block turns a linear framebuffer in external memory into a VGA picture. A counter-based timing generator in the pixel clock domain produces the line and frame structure and the active-low sync pulses. Pixel words come from an external burst reader running on the memory clock. They enter a dual-clock FIFO with Gray-coded pointers and leave it one per visible pixel. Each memory word carries one pixel: the low 16 bits hold an RGB565 colour and the upper 16 bits are discarded.

On the memory side a small state machine paces the reader. When the FIFO has room for one whole burst and nothing is in flight, it sends a single-cycle request and then counts the returned beats. The vertical sync output goes to the reader, which holds its fetch address at the frame base while the pulse is low. During that same pulse the pixel side discards any data it fetched ahead of time, so every frame starts from memory word 0. If the FIFO runs dry during active video, the output is black and a sticky error flag is set.

The memory-side state machine has four states. `F_IDLE` moves to `F_FLUSH` when the synchronised vertical sync is low. Otherwise it moves to `F_REQ` once the free space is at least one burst. `F_REQ` lasts one cycle and always moves on to `F_WAIT`. `F_WAIT` counts beats; after the last beat it moves to `F_FLUSH` if vertical sync is low and to `F_IDLE` if not. `F_FLUSH` returns to `F_IDLE` when vertical sync goes high again.

Top module: `fb_scanout`

## Requirements
- R1: While both resets are held: `hsync_n` and `vsync_n` are 1, `rgb` is 0, `underflow` is 0 and `fetch_req` is 0.
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP pixel clocks. `hsync_n` is 0 for H_SYNC clocks, starting H_ACTIVE+H_FP clocks after the line begins.
- R3: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. `vsync_n` is 0 for V_SYNC whole lines, starting at line V_ACTIVE+V_FP. After reset the count begins at the first line after the active area (line V_ACTIVE, pixel 0).
- R4: The visible pixel at column x and row y shows bits [15:0] of word x + H_ACTIVE*y of the frame. Words are numbered from the first word delivered after the reader rewinds. Bits [31:16] have no effect on `rgb`.
- R5: `rgb` is 0 on every clock outside the visible area.
- R6: Pixel (0,0) of every frame shows word 0. This holds even when the FIFO fetched words past the end of the previous frame.
- R7: `fetch_req` is high for exactly one memory clock. It is raised only when at least BURST words of the FIFO are free. No new request follows until all BURST beats of the previous one have arrived.
- R8: No request is raised more than four memory clocks after `vsync_n` has gone low, for as long as it stays low.
- R9: A visible pixel that finds the FIFO empty is driven as 0 and sets `underflow`, which stays 1 until reset. While data keeps up, `underflow` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Active-low reset, pixel domain |
| mem_clk | input | 1 | Memory-bus clock |
| mem_rst_n | input | 1 | Active-low reset, memory domain |
| rd_data | input | 32 | Read-data word from the burst reader |
| rd_valid | input | 1 | rd_data carries a beat this clock |
| fetch_req | output | 1 | One-cycle request for the next burst |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low; also the reader's address rewind |
| rgb | output | 16 | RGB565 colour, zero in blanking |
| underflow | output | 1 | Sticky FIFO-underflow flag |

## Verification
The two clocks run at 25 MHz and 50 MHz. The memory model inserts gaps at irregular points in its beat stream, so FIFO fill levels and request timing differ from burst to burst. Every word holds a scrambled colour in its low half and a different pattern in its high half. A pixel that is shifted by one word, or taken from the upper bits, therefore shows up at once. Several frames in a row test that the prefetched surplus is discarded and each frame starts at word 0. A final frame in which the memory stops serving requests separates the underflow path (black pixels, sticky flag) from normal scanout.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_WAIT,
        F_FLUSH
    } fetch_state_t;
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33
) (
    input  logic clk,
    input  logic rst_n,
    output logic active,
    output logic hs_n,
    output logic vs_n
);
    localparam int HT = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int VT = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW = $clog2(HT);
    localparam int VW = $clog2(VT);
    localparam logic [HW-1:0] H_LAST  = HW'(HT - 1);
    localparam logic [VW-1:0] V_LAST  = VW'(VT - 1);
    localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
    localparam logic [HW-1:0] HS_BEG  = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] HS_END  = HW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_BEG  = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] VS_END  = VW'(V_ACTIVE + V_FP + V_SYNC);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= V_VIS;
        end else if (hcnt == H_LAST) begin
            hcnt <= '0;
            vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        active = (hcnt < H_VIS) && (vcnt < V_VIS);
        hs_n   = !((hcnt >= HS_BEG) && (hcnt < HS_END));
        vs_n   = !((vcnt >= VS_BEG) && (vcnt < VS_END));
    end
endmodule

// File: rtl/gray_fifo.sv
module gray_fifo #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    output logic [AW:0]   wfree,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          ren,
    input  logic          flush,
    output logic [DW-1:0] rdata,
    output logic          rempty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
    logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, rbin_nx;

    // write domain
    always_ff @(posedge wclk) begin
        if (wen) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rgray;
            rg_s2 <= rg_s1;
            if (wen) begin
                wbin  <= wbin + 1'b1;
                wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
            end
        end
    end

    assign wfree = PW'(DEPTH) - (wbin - g2b(rg_s2));

    // read domain; a flush jumps the read pointer onto the synchronised write pointer
    assign rempty = (rgray == wg_s2);
    assign rdata  = mem[rbin[AW-1:0]];

    always_comb begin
        if (flush)               rbin_nx = g2b(wg_s2);
        else if (ren && !rempty) rbin_nx = rbin + 1'b1;
        else                     rbin_nx = rbin;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            wg_s1 <= wgray;
            wg_s2 <= wg_s1;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import scan_pkg::*;
#(
    parameter int BURST = 16,
    parameter int AW    = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vs_n_async,
    input  logic        beat,
    input  logic [AW:0] free,
    output logic        fetch_req
);
    localparam int CW = (BURST > 1) ? $clog2(BURST) : 1;
    localparam logic [CW-1:0] LAST_BEAT = CW'(BURST - 1);
    localparam logic [AW:0]   ROOM      = (AW+1)'(BURST);

    fetch_state_t state, nxt;
    logic         vs_s1, vs_s2;
    logic [CW-1:0] bcnt;
    logic          vs_low, last;

    assign vs_low = !vs_s2;
    assign last   = (bcnt == LAST_BEAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_s1 <= 1'b1;
            vs_s2 <= 1'b1;
        end else begin
            vs_s1 <= vs_n_async;
            vs_s2 <= vs_s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            F_IDLE:  if (vs_low)              nxt = F_FLUSH;
                     else if (free >= ROOM)   nxt = F_REQ;
            F_REQ:                            nxt = F_WAIT;
            F_WAIT:  if (beat && last)        nxt = vs_low ? F_FLUSH : F_IDLE;
            F_FLUSH: if (!vs_low)             nxt = F_IDLE;
            default:                          nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       bcnt <= '0;
        else if (state == F_WAIT && beat) bcnt <= last ? '0 : bcnt + 1'b1;
    end

    always_comb begin
        fetch_req = (state == F_REQ);
    end
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int WORD_W   = 32,
    parameter int PIX_W    = 16,
    parameter int FIFO_AW  = 6,
    parameter int BURST    = 16
) (
    input  logic              pix_clk,
    input  logic              pix_rst_n,
    input  logic              mem_clk,
    input  logic              mem_rst_n,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              fetch_req,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic [PIX_W-1:0]  rgb,
    output logic              underflow
);
    logic               pix_active, hs_c, vs_c;
    logic [FIFO_AW:0]   wr_free;
    logic [PIX_W-1:0]   fifo_q;
    logic               fifo_empty;
    logic               take;

    vga_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_timing (
        .clk(pix_clk), .rst_n(pix_rst_n),
        .active(pix_active), .hs_n(hs_c), .vs_n(vs_c)
    );

    gray_fifo #(.DW(PIX_W), .AW(FIFO_AW)) u_fifo (
        .wclk(mem_clk), .wrst_n(mem_rst_n), .wen(rd_valid),
        .wdata(rd_data[PIX_W-1:0]), .wfree(wr_free),
        .rclk(pix_clk), .rrst_n(pix_rst_n), .ren(take), .flush(!vs_c),
        .rdata(fifo_q), .rempty(fifo_empty)
    );

    fetch_ctrl #(.BURST(BURST), .AW(FIFO_AW)) u_fetch (
        .clk(mem_clk), .rst_n(mem_rst_n), .vs_n_async(vsync_n),
        .beat(rd_valid), .free(wr_free), .fetch_req(fetch_req)
    );

    assign take = pix_active && !fifo_empty;

    always_ff @(posedge pix_clk or negedge pix_rst_n) begin
        if (!pix_rst_n) begin
            hsync_n   <= 1'b1;
            vsync_n   <= 1'b1;
            rgb       <= '0;
            underflow <= 1'b0;
        end else begin
            hsync_n <= hs_c;
            vsync_n <= vs_c;
            rgb     <= take ? fifo_q : '0;
            if (pix_active && fifo_empty) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/fb_scanout_chk.sv
module fb_scanout_chk #(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 16,
    parameter int AW     = 6,
    parameter int BURST  = 16
) (
    input logic              mem_clk,
    input logic              mem_rst_n,
    input logic              fetch_req,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic [AW:0]       wr_free,
    input logic              pix_clk,
    input logic              pix_rst_n,
    input logic              pix_active,
    input logic [PIX_W-1:0]  rgb,
    input logic              underflow
);
    localparam logic [AW:0] ROOM = (AW+1)'(BURST);

    AST_REQ_PULSE: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        fetch_req |=> !fetch_req);                                   // R7
    AST_REQ_ROOM: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        fetch_req |-> wr_free >= ROOM);                              // R7
    AST_NO_OVERFLOW: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        rd_valid |-> wr_free != '0);                                 // R7
    AST_DATA_KNOWN: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
        rd_valid |-> !$isunknown(rd_data));                          // R4
    AST_BLANK_BLACK: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        !pix_active |=> rgb == '0);                                  // R5
    AST_UNDERFLOW_STICKY: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        underflow |=> underflow);                                    // R9
endmodule

bind fb_scanout fb_scanout_chk #(
    .WORD_W(WORD_W), .PIX_W(PIX_W), .AW(FIFO_AW), .BURST(BURST)
) u_chk (
    .mem_clk(mem_clk), .mem_rst_n(mem_rst_n), .fetch_req(fetch_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_free(wr_free),
    .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pix_active(pix_active),
    .rgb(rgb), .underflow(underflow)
);

// File: tb/test_fb_scanout.sv
module test_fb_scanout;
    localparam int HA = 16, HFP = 2, HS = 3, HBP = 3;
    localparam int VA = 6,  VFP = 1, VS = 2, VBP = 2;
    localparam int HT = HA + HFP + HS + HBP;
    localparam int VT = VA + VFP + VS + VBP;
    localparam int BURST = 16;

    logic        pix_clk = 0, mem_clk = 0;
    logic        pix_rst_n = 0, mem_rst_n = 0;
    logic [31:0] rd_data = '0;
    logic        rd_valid = 0;
    logic        fetch_req, hsync_n, vsync_n, underflow;
    logic [15:0] rgb;

    int vectors = 0, fails = 0;

    always #10 mem_clk = ~mem_clk;   // 50 MHz
    always #20 pix_clk = ~pix_clk;   // 25 MHz

    fb_scanout #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
        .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
        .BURST(BURST)
    ) i_fb_scanout (
        .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .mem_clk(mem_clk), .mem_rst_n(mem_rst_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .fetch_req(fetch_req),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb), .underflow(underflow)
    );

    function automatic logic [15:0] colour(int idx);
        return 16'(idx * 40503 + 7);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [15:0] exp_q[$];
    bit          stall = 0;

    task automatic push_frame(bit black);
        for (int i = 0; i < HA * VA; i++) exp_q.push_back(black ? 16'h0 : colour(i));
    endtask

    bit tracking = 0;
    bit prev_vs  = 1;
    int hx = 0, vy = 0;

    always @(negedge pix_clk) begin
        if (pix_rst_n) begin
            if (!tracking && prev_vs && !vsync_n) begin
                tracking = 1;
                hx = 0;
                vy = VA + VFP;
            end
            if (tracking) begin
                check(hsync_n == !(hx >= HA + HFP && hx < HA + HFP + HS), "R2", hsync_n, !hsync_n);
                check(vsync_n == !(vy >= VA + VFP && vy < VA + VFP + VS), "R3", vsync_n, !vsync_n);
                if (hx < HA && vy < VA) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R4", rgb, 0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        if (stall)                 check(rgb == e, "R9", rgb, e);
                        else if (hx == 0 && vy == 0) check(rgb == e, "R6", rgb, e);
                        else                       check(rgb == e, "R4", rgb, e);
                    end
                end else begin
                    check(rgb == 16'h0, "R5", rgb, 0);
                end
                if (hx == HT - 1) begin
                    hx = 0;
                    vy = (vy == VT - 1) ? 0 : vy + 1;
                end else hx++;
            end
        end
        prev_vs = vsync_n;
    end

    // ---------------- memory / burst reader model ----------------
    int       addr = 0, base = 0, beat = 0, lat = 0, vs_low_cnt = 0;
    bit       busy = 0, prev_req = 0;
    logic [7:0] lfsr = 8'h5B;

    always @(posedge mem_clk) begin
        if (mem_rst_n) begin
            vs_low_cnt = vsync_n ? 0 : vs_low_cnt + 1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (fetch_req) begin
                check(!prev_req, "R7", prev_req, 0);
                check(!busy, "R7", busy, 0);
                check(vs_low_cnt <= 4, "R8", vs_low_cnt, 4);
            end
            prev_req = fetch_req;
            rd_valid <= 1'b0;
            if (busy) begin
                if (lat > 0) lat--;
                else if (lfsr[0] | lfsr[1]) begin
                    rd_valid <= 1'b1;
                    rd_data  <= {16'(base + beat) ^ 16'hC3A5, colour(base + beat)};
                    if (beat == BURST - 1) busy = 0;
                    beat++;
                end
            end
            if (fetch_req && !busy && !stall) begin
                busy = 1;
                base = addr;
                beat = 0;
                lat  = 2;
                if (vsync_n) addr += BURST;
            end
            if (!vsync_n) addr = 0;
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    bit done = 0;
    always @(posedge mem_clk) begin
        wd++;
        if (wd == 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- driver ----------------
    initial begin
        repeat (6) @(posedge mem_clk);
        @(negedge pix_clk);
        check(hsync_n == 1'b1, "R1", hsync_n, 1);
        check(vsync_n == 1'b1, "R1", vsync_n, 1);
        check(rgb == 16'h0, "R1", rgb, 0);
        check(underflow == 1'b0, "R1", underflow, 0);
        check(fetch_req == 1'b0, "R1", fetch_req, 0);
        @(negedge mem_clk);
        mem_rst_n = 1;
        @(negedge pix_clk);
        pix_rst_n = 1;

        for (int f = 0; f < 3; f++) begin
            @(negedge vsync_n);
            check(underflow == 1'b0, "R9", underflow, 0);
            push_frame(0);
        end
        @(negedge vsync_n);
        check(underflow == 1'b0, "R9", underflow, 0);
        stall = 1;
        push_frame(1);
        wait (exp_q.size() == 0);
        repeat (3) @(negedge pix_clk);
        check(underflow == 1'b1, "R9", underflow, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule